// File: doc/BRIEF.md
# PCM Frame-Sync Serial Port

This block moves 8-bit companded voice samples between a parallel interface and a pair of framed serial lines. On the transmit side a byte is shifted out most significant (sign) bit first on a data pin that is driven only while bits are being sent. On the receive side a byte is collected from a data pin and handed over in parallel with a single-cycle strobe. Each direction has its own bit clock and its own frame sync. Both bit clocks are plain levels sampled by one system clock. Rising and falling edges are found by comparing each sample with the one before.

Two framing styles are supported. In the short style the sync is one bit period wide and the data lags it by one bit. In the long style the sync spans three or more bit periods and the sign bit goes out together with the sync. The port works out the style by itself from the width of the transmit sync and applies it from the next frame on. The byte sent in a frame is the parallel word that was taken in at the start of the frame before, which gives one frame of latency for the encoder side.

Top module: `pcm_fs_port`

## Requirements
- R1: Each frame sends exactly 8 bits on `tx_dout`, bit 7 (sign) first and bit 0 last, with `tx_oe` high for the whole of the transfer.
- R2: In short mode, a falling edge of `tx_bclk` that samples `tx_sync` high (after one that sampled it low) makes the next rising edge raise `tx_oe` and present bit 7. Each of the seven rising edges after that presents the next bit.
- R3: In short mode, the first falling edge of `tx_bclk` after the bit-0 rising edge drops `tx_oe`.
- R4: In short mode, a falling edge of `rx_bclk` that samples `rx_sync` high (after one that sampled it low) arms the receiver. The next eight falling edges capture `rx_din` as bit 7 down to bit 0.
- R5: After reset `tx_oe`, `rx_valid` and `long_mode` are 0, so the port starts in short mode.
- R6: When `tx_sync` falls, `long_mode` becomes 1 if the sync was high across 3 or more falling edges of `tx_bclk`, and 0 if it spanned 1 or 2. The new mode governs the following frames. `long_mode` changes at no other time, and the width of `rx_sync` has no effect on it.
- R7: In long mode, the rising edge of `tx_sync` raises `tx_oe` and presents bit 7. The next seven rising edges of `tx_bclk` present bits 6 to 0.
- R8: In long mode, `tx_oe` drops at whichever comes later: the first falling edge after the bit-0 rising edge, or `tx_sync` going low.
- R9: The byte sent in a frame is the `tx_word` value taken at the start of the previous frame. The first frame after reset sends 0x00.
- R10: One system clock after the falling edge that captures the eighth bit, `rx_word` holds the byte and `rx_valid` is high for exactly one cycle. `rx_word` changes at no other time.
- R11: In long mode, the first falling edge of `rx_bclk` that samples `rx_sync` high captures bit 7. The next seven falling edges capture bits 6 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples both bit clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bclk | input | 1 | Transmit bit clock level |
| tx_sync | input | 1 | Transmit frame sync; its width sets the mode |
| tx_word | input | 8 | Parallel byte for a later frame |
| tx_dout | output | 1 | Serial transmit data, valid while tx_oe is high |
| tx_oe | output | 1 | Output-driver enable for tx_dout (high = driven) |
| rx_bclk | input | 1 | Receive bit clock level |
| rx_sync | input | 1 | Receive frame sync |
| rx_din | input | 1 | Serial receive data |
| rx_word | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when rx_word is updated |
| long_mode | output | 1 | Current framing style (1 = long) |

## Verification
The port is driven with frames whose transmit sync lasts 1, 2, 3 and 10 bit periods. These separate the short and long detection thresholds, the switch from one mode to the next frame, and the case where a long sync outlasts the eight data bits and holds the driver on. A frame with a long receive sync and a short transmit sync shows that only the transmit side sets the mode. Byte patterns 0x00, 0xFF, 0x80, 0x01 and alternating bits show bit order and the one-frame transmit latency. The enable checks sample `tx_oe` in the bit period just before and just after each edge where it should change.

// File: rtl/pcm_fs_pkg.sv
package pcm_fs_pkg;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_ARMED = 2'd1,
      TX_SHIFT = 2'd2,
      TX_TAIL  = 2'd3
   } tx_state_e;

   typedef enum logic {
      RX_IDLE  = 1'b0,
      RX_SHIFT = 1'b1
   } rx_state_e;

   localparam int unsigned N_BCLK = 2;
   localparam int unsigned IDX_TX = 0;
   localparam int unsigned IDX_RX = 1;

endpackage

// File: rtl/pcm_fs_edge.sv
module pcm_fs_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

endmodule

// File: rtl/pcm_fs_mode.sv
module pcm_fs_mode #(
   parameter int unsigned LONG_MIN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync,
   input  logic bclk_fall,
   output logic sync_rise,
   output logic long_mode
);
   localparam int unsigned MCW = $clog2(LONG_MIN + 1);
   localparam logic [MCW-1:0] LIM = MCW'(LONG_MIN);

   logic           sync_prev_q;
   logic [MCW-1:0] width_q;
   logic           sync_drop;

   assign sync_rise = sync & ~sync_prev_q;
   assign sync_drop = ~sync & sync_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_prev_q <= 1'b0;
         width_q     <= '0;
         long_mode   <= 1'b0;
      end else begin
         sync_prev_q <= sync;
         if (!sync)
            width_q <= '0;
         else if (bclk_fall && width_q < LIM)
            width_q <= width_q + 1'b1;
         if (sync_drop)
            long_mode <= (width_q >= LIM);
      end
   end

   // R6
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_drop |=> $stable(long_mode));

endmodule

// File: rtl/pcm_fs_tx.sv
module pcm_fs_tx
   import pcm_fs_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             fall,
   input  logic             sync,
   input  logic             sync_rise,
   input  logic             long_mode,
   input  logic [WIDTH-1:0] word,
   output logic             dout,
   output logic             oe
);
   localparam int unsigned CW   = $clog2(WIDTH);
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);
   localparam int unsigned MSB  = WIDTH - 1;

   tx_state_e        state_q;
   logic [CW-1:0]    cnt_q;
   logic [WIDTH-1:0] sh_q;
   logic [WIDTH-1:0] hold_q;
   logic             fall_sync_q;
   logic             short_go;
   logic             long_go;

   assign long_go  = (state_q == TX_IDLE) && long_mode && sync_rise;
   assign short_go = (state_q == TX_IDLE) && !long_mode && fall && sync && !fall_sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= TX_IDLE;
         cnt_q       <= '0;
         sh_q        <= '0;
         hold_q      <= '0;
         fall_sync_q <= 1'b0;
         dout        <= 1'b0;
         oe          <= 1'b0;
      end else begin
         if (fall) fall_sync_q <= sync;
         unique case (state_q)
            TX_IDLE: begin
               if (long_go) begin
                  dout    <= hold_q[MSB];
                  sh_q    <= hold_q << 1;
                  hold_q  <= word;
                  oe      <= 1'b1;
                  cnt_q   <= '0;
                  state_q <= TX_SHIFT;
               end else if (short_go) begin
                  sh_q    <= hold_q;
                  hold_q  <= word;
                  state_q <= TX_ARMED;
               end
            end
            TX_ARMED: begin
               if (rise) begin
                  dout    <= sh_q[MSB];
                  sh_q    <= sh_q << 1;
                  oe      <= 1'b1;
                  cnt_q   <= '0;
                  state_q <= TX_SHIFT;
               end
            end
            TX_SHIFT: begin
               if (rise && cnt_q != LAST) begin
                  dout  <= sh_q[MSB];
                  sh_q  <= sh_q << 1;
                  cnt_q <= cnt_q + 1'b1;
               end else if (fall && cnt_q == LAST) begin
                  if (!sync) begin
                     oe      <= 1'b0;
                     state_q <= TX_IDLE;
                  end else begin
                     state_q <= TX_TAIL;
                  end
               end
            end
            TX_TAIL: begin
               if (!sync) begin
                  oe      <= 1'b0;
                  state_q <= TX_IDLE;
               end
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   // R8
   oe_held_by_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && sync) |=> oe);

   // R1
   dout_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && !rise) |=> $stable(dout));

   // R2
   oe_start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe && !rise && !sync_rise) |=> !oe);

endmodule

// File: rtl/pcm_fs_rx.sv
module pcm_fs_rx
   import pcm_fs_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fall,
   input  logic             sync,
   input  logic             din,
   input  logic             long_mode,
   output logic [WIDTH-1:0] word,
   output logic             valid
);
   localparam int unsigned CW   = $clog2(WIDTH);
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   rx_state_e        state_q;
   logic [CW-1:0]    cnt_q;
   logic [WIDTH-1:0] sh_q;
   logic             fall_sync_q;
   logic             trig;

   assign trig = (state_q == RX_IDLE) && fall && sync && !fall_sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= RX_IDLE;
         cnt_q       <= '0;
         sh_q        <= '0;
         fall_sync_q <= 1'b0;
         word        <= '0;
         valid       <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (fall) fall_sync_q <= sync;
         unique case (state_q)
            RX_IDLE: begin
               if (trig) begin
                  state_q <= RX_SHIFT;
                  if (long_mode) begin
                     sh_q  <= {sh_q[WIDTH-2:0], din};
                     cnt_q <= CW'(1);
                  end else begin
                     cnt_q <= '0;
                  end
               end
            end
            RX_SHIFT: begin
               if (fall) begin
                  sh_q  <= {sh_q[WIDTH-2:0], din};
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == LAST) begin
                     word    <= {sh_q[WIDTH-2:0], din};
                     valid   <= 1'b1;
                     state_q <= RX_IDLE;
                  end
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   // R10
   rx_valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R10
   rx_word_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fall |=> ($stable(word) && !valid));

endmodule

// File: rtl/pcm_fs_port.sv
module pcm_fs_port
   import pcm_fs_pkg::*;
#(
   parameter int unsigned WIDTH    = 8,
   parameter int unsigned LONG_MIN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_bclk,
   input  logic             tx_sync,
   input  logic [WIDTH-1:0] tx_word,
   output logic             tx_dout,
   output logic             tx_oe,
   input  logic             rx_bclk,
   input  logic             rx_sync,
   input  logic             rx_din,
   output logic [WIDTH-1:0] rx_word,
   output logic             rx_valid,
   output logic             long_mode
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("pcm_fs_port: WIDTH must be at least 2");
      end
      if (LONG_MIN < 3) begin : g_bad_long
         $error("pcm_fs_port: LONG_MIN must be at least 3");
      end
   endgenerate

   logic [N_BCLK-1:0] bclk_lvl;
   logic [N_BCLK-1:0] bclk_rise;
   logic [N_BCLK-1:0] bclk_fall;
   logic              tx_sync_rise;

   assign bclk_lvl[IDX_TX] = tx_bclk;
   assign bclk_lvl[IDX_RX] = rx_bclk;

   for (genvar g = 0; g < N_BCLK; g++) begin : g_edge
      pcm_fs_edge u_edge (
         .clk  (clk),
         .rst_n(rst_n),
         .lvl  (bclk_lvl[g]),
         .rise (bclk_rise[g]),
         .fall (bclk_fall[g])
      );
   end

   pcm_fs_mode #(.LONG_MIN(LONG_MIN)) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync     (tx_sync),
      .bclk_fall(bclk_fall[IDX_TX]),
      .sync_rise(tx_sync_rise),
      .long_mode(long_mode)
   );

   pcm_fs_tx #(.WIDTH(WIDTH)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (bclk_rise[IDX_TX]),
      .fall     (bclk_fall[IDX_TX]),
      .sync     (tx_sync),
      .sync_rise(tx_sync_rise),
      .long_mode(long_mode),
      .word     (tx_word),
      .dout     (tx_dout),
      .oe       (tx_oe)
   );

   pcm_fs_rx #(.WIDTH(WIDTH)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall     (bclk_fall[IDX_RX]),
      .sync     (rx_sync),
      .din      (rx_din),
      .long_mode(long_mode),
      .word     (rx_word),
      .valid    (rx_valid)
   );

   // R5
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!tx_oe && !rx_valid && !long_mode));

endmodule

// File: tb/pcm_fs_port_tb_top.sv
module pcm_fs_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_bclk = 1'b0, tx_sync = 1'b0, tx_dout, tx_oe;
   logic [7:0] tx_word = 8'h00;
   logic       rx_bclk = 1'b0, rx_sync = 1'b0, rx_din = 1'b0;
   logic [7:0] rx_word;
   logic       rx_valid, long_mode;

   int  n_chk = 0, n_fail = 0;
   bit  done = 0;
   logic [7:0] txq[$];
   logic [7:0] rxq[$];
   logic [7:0] hold_model = 8'h00;
   bit  model_long = 0;

   always #2 clk = ~clk;

   pcm_fs_port dut_i (
      .clk(clk), .rst_n(rst_n),
      .tx_bclk(tx_bclk), .tx_sync(tx_sync), .tx_word(tx_word),
      .tx_dout(tx_dout), .tx_oe(tx_oe),
      .rx_bclk(rx_bclk), .rx_sync(rx_sync), .rx_din(rx_din),
      .rx_word(rx_word), .rx_valid(rx_valid), .long_mode(long_mode)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: one frame on both directions, syncs of the given widths
   task automatic frame(input int tx_len, input int rx_len,
                        input logic [7:0] txw, input logic [7:0] rxw);
      int start, off, nper;
      start = model_long ? 0 : 1;
      if (model_long) off = (tx_len > 8) ? tx_len : 8;
      else            off = (tx_len > 9) ? tx_len : 9;
      nper = ((off > rx_len) ? off : rx_len) + 2;
      txq.push_back(hold_model);
      hold_model = txw;
      rxq.push_back(rxw);
      tx_word = txw;
      for (int p = 0; p < nper; p++) begin
         @(negedge clk);
         tx_bclk = 1'b1; rx_bclk = 1'b1;
         tx_sync = (p < tx_len);
         rx_sync = (p < rx_len);
         rx_din  = (p >= start && p < start + 8) ? rxw[7 - (p - start)] : 1'b0;
         @(posedge clk); @(posedge clk); #1;
         if (p == start - 1) chk(tx_oe == 1'b0, "R2 oe before start", tx_oe, 0);
         if (p == start)     chk(tx_oe == 1'b1, model_long ? "R7 oe at sync rise" : "R2 oe at rise", tx_oe, 1);
         if (p == off - 1)   chk(tx_oe == 1'b1, model_long ? "R8 oe held" : "R3 oe held", tx_oe, 1);
         if (p == off)       chk(tx_oe == 1'b0, model_long ? "R8 oe released" : "R3 oe released", tx_oe, 0);
         @(negedge clk);
         tx_bclk = 1'b0; rx_bclk = 1'b0;
         @(posedge clk); @(posedge clk);
      end
      model_long = (tx_len >= 3);
      #1;
      chk(long_mode == model_long, "R6 mode after frame", long_mode, model_long);
   endtask

   // monitor: transmit side
   initial begin
      logic [7:0] got;
      forever begin
         @(posedge tx_oe);
         got = 8'h00;
         for (int k = 0; k < 8; k++) begin
            if (k == 0) @(negedge clk);
            else repeat (4) @(negedge clk);
            got[7 - k] = tx_dout;
            chk(tx_oe == 1'b1, "R1 oe during bits", tx_oe, 1);
         end
         if (txq.size() == 0) chk(1'b0, "R1 R9 unexpected frame", got, 0);
         else begin
            logic [7:0] exp;
            exp = txq.pop_front();
            chk(got == exp, "R1 R9 tx byte", got, exp);
         end
      end
   end

   // monitor: receive side
   initial begin
      forever begin
         @(negedge clk);
         if (rx_valid) begin
            if (rxq.size() == 0) chk(1'b0, "R10 unexpected strobe", rx_word, 0);
            else begin
               logic [7:0] exp;
               exp = rxq.pop_front();
               chk(rx_word == exp, "R4 R11 R10 rx byte", rx_word, exp);
            end
            @(negedge clk);
            chk(rx_valid == 1'b0, "R10 single strobe", rx_valid, 0);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R5
      chk(tx_oe == 1'b0,     "R5 oe after reset", tx_oe, 0);
      chk(rx_valid == 1'b0,  "R5 valid after reset", rx_valid, 0);
      chk(long_mode == 1'b0, "R5 mode after reset", long_mode, 0);
      repeat (4) @(posedge clk);
      frame(1, 1, 8'hA5, 8'h3C);   // short, sends 00 (R9)
      frame(2, 2, 8'hFF, 8'h80);   // two-period sync stays short (R6)
      frame(1, 4, 8'h80, 8'h01);   // long rx sync ignored for mode (R6)
      frame(3, 3, 8'h01, 8'h55);   // short timing, switches to long
      frame(3, 3, 8'h55, 8'hAA);   // long (R7 R8 R11)
      frame(10, 10, 8'hAA, 8'hFF); // long sync outlasts data (R8)
      frame(1, 1, 8'h00, 8'h00);   // long timing, back to short
      frame(1, 1, 8'h3C, 8'hC3);   // short again
      repeat (40) @(posedge clk);
      chk(txq.size() == 0, "R1 all tx frames seen", txq.size(), 0);
      chk(rxq.size() == 0, "R10 all rx bytes seen", rxq.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule